// File: doc/BRIEF.md
# FIFO Occupancy Anomaly Monitor

This block sits in the read clock domain of a buffer and watches its fill level together with the read and write events that explain each change of that level. A correctly working pair of pointers can only move the fill level in small, explained steps. A step that is too large, a rise that only a read accompanied, or a fall that only a write accompanied shows that a pointer has gone wrong. The block flags each such anomaly with a one-cycle trigger pulse on an output pin that a logic analyzer can trigger on. It also keeps a sticky error flag and a code that names the first anomaly seen.

Each fill sample comes with a valid qualifier and with two event bits. The event bits say whether a read and/or a write took place between the previous valid sample and this one. Comparison always runs between consecutive valid samples. The first valid sample after reset only sets the reference. The sticky flag and the code stay set until software or a test harness pulses the clear input.

Top module: `fillAnomalyMon`

## Requirements
- R1: During and right after reset, trigPulse, errSticky and errCode are all 0.
- R2: The first valid sample after reset is never flagged, whatever its value. It only becomes the reference for the next valid sample.
- R3: A valid sample whose fill differs from the previous valid sample by more than MAX_STEP (default 4) is a violation with code 1. A difference of exactly MAX_STEP is not.
- R4: A valid sample with a read event, no write event and a fill above the previous valid fill is a violation with code 2.
- R5: A valid sample with a write event, no read event and a fill below the previous valid fill is a violation with code 3.
- R6: A change within MAX_STEP is not a violation when both events or neither event accompany it.
- R7: trigPulse is high for exactly the one clock cycle that follows the edge at which a violating sample was captured. Back-to-back violating samples give back-to-back pulses.
- R8: After a violation errSticky stays 1, and errCode keeps the code of the first violation even when later violations occur.
- R9: A cycle with clearErr high returns errSticky and errCode to 0. If a violation is captured in the same cycle, that violation sets the flag and its code instead.
- R10: When a jump and a rise-on-read or fall-on-write happen together, the reported code is 1.
- R11: Samples with fillValid low are neither checked nor used as the reference, and their event bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-domain clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillLevel | input | FILL_W (5) | Read-side fill level of the buffer |
| fillValid | input | 1 | fillLevel carries a valid sample this cycle |
| rdEvent | input | 1 | A read occurred since the previous valid sample |
| wrEvent | input | 1 | A write (synchronized) occurred since the previous valid sample |
| clearErr | input | 1 | Clears the sticky flag and the code |
| trigPulse | output | 1 | One-cycle pulse per violating sample |
| errSticky | output | 1 | Set by any violation, held until cleared |
| errCode | output | 2 | 0 none, 1 jump, 2 rise on read, 3 fall on write |

## Verification
The bench places the reference sample far from zero, so a design that compared the first sample against the reset value would raise a false jump. It tries a step of exactly MAX_STEP beside one of MAX_STEP+1 to catch an off-by-one in the bound. It sends an invalid sample with an extreme value and then a small read-side rise. A design that took the invalid sample as its reference would report a jump instead of a rise. It also drives a clear and a violation in the same cycle, and a jump that is also a rise on read. These catch a design that loses the new error or reports the wrong code.

// File: rtl/fam_pkg.sv
package fam_pkg;

  typedef enum logic [1:0] {
    VIOL_NONE    = 2'd0,
    VIOL_JUMP    = 2'd1,
    VIOL_RISE_RD = 2'd2,
    VIOL_FALL_WR = 2'd3
  } violCode_t;

  // raw comparison hits produced by the datapath
  typedef struct packed {
    logic jump;
    logic riseOnRd;
    logic fallOnWr;
  } famHits_t;

  // strobes from control back into the datapath
  typedef struct packed {
    logic      fire;
    logic      clear;
    violCode_t code;
  } famStrobe_t;

endpackage

// File: rtl/fam_control.sv
module fam_control
  import fam_pkg::*;
(
  input  famHits_t   hits,
  input  logic       clearErr,
  output famStrobe_t strobe
);

  always_comb begin
    strobe.fire  = hits.jump | hits.riseOnRd | hits.fallOnWr;
    strobe.clear = clearErr;
    // jump outranks the directional checks
    if (hits.jump)
      strobe.code = VIOL_JUMP;
    else if (hits.riseOnRd)
      strobe.code = VIOL_RISE_RD;
    else if (hits.fallOnWr)
      strobe.code = VIOL_FALL_WR;
    else
      strobe.code = VIOL_NONE;
  end

endmodule

// File: rtl/fam_datapath.sv
module fam_datapath
  import fam_pkg::*;
#(
  parameter int FILL_W   = 5,
  parameter int MAX_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic              fillValid,
  input  logic              rdEvent,
  input  logic              wrEvent,
  input  famStrobe_t        strobe,
  output famHits_t          hits,
  output logic              trigPulse,
  output logic              errSticky,
  output violCode_t         errCode
);

  localparam int DW       = FILL_W + 1;
  localparam int FILL_MAX = (1 << FILL_W) - 1;

  logic [FILL_W-1:0] prevFill;
  logic              armed;
  logic              checkNow;
  logic [DW-1:0]     delta;
  logic [DW-1:0]     absDelta;
  logic              tooFar;

  assign checkNow = fillValid & armed;
  assign delta    = {1'b0, fillLevel} - {1'b0, prevFill};
  assign absDelta = delta[DW-1] ? (~delta + 1'b1) : delta;

  generate
    if (MAX_STEP >= FILL_MAX) begin : g_noJump
      // no fill change can exceed the bound
      assign tooFar = 1'b0;
    end else begin : g_jump
      localparam logic [DW-1:0] STEP_LIM = DW'(MAX_STEP);
      assign tooFar = absDelta > STEP_LIM;
    end
  endgenerate

  always_comb begin
    hits.jump     = checkNow & tooFar;
    hits.riseOnRd = checkNow & rdEvent & ~wrEvent & (fillLevel > prevFill);
    hits.fallOnWr = checkNow & wrEvent & ~rdEvent & (fillLevel < prevFill);
  end

  // reference sample tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFill <= '0;
      armed    <= 1'b0;
    end else if (fillValid) begin
      prevFill <= fillLevel;
      armed    <= 1'b1;
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigPulse <= 1'b0;
      errSticky <= 1'b0;
      errCode   <= VIOL_NONE;
    end else begin
      trigPulse <= strobe.fire;
      if (strobe.fire) begin
        errSticky <= 1'b1;
        if (!errSticky || strobe.clear)
          errCode <= strobe.code;
      end else if (strobe.clear) begin
        errSticky <= 1'b0;
        errCode   <= VIOL_NONE;
      end
    end
  end

  p_first_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !armed |=> !trigPulse);

  p_invalid_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !fillValid |=> !trigPulse);

  p_pulse_sets_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> errSticky);

  p_code_named_r8: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |-> errCode != VIOL_NONE);

  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    errSticky && !strobe.clear |=> $stable(errCode) && errSticky);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear && !strobe.fire |=> !errSticky && errCode == VIOL_NONE);

endmodule

// File: rtl/fillAnomalyMon.sv
module fillAnomalyMon
  import fam_pkg::*;
#(
  parameter int FILL_W   = 5,
  parameter int MAX_STEP = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILL_W-1:0] fillLevel,
  input  logic              fillValid,
  input  logic              rdEvent,
  input  logic              wrEvent,
  input  logic              clearErr,
  output logic              trigPulse,
  output logic              errSticky,
  output logic [1:0]        errCode
);

  famHits_t   hits;
  famStrobe_t strobe;
  violCode_t  codeQ;

  fam_datapath #(.FILL_W(FILL_W), .MAX_STEP(MAX_STEP)) uData (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .fillValid(fillValid),
    .rdEvent(rdEvent), .wrEvent(wrEvent), .strobe(strobe), .hits(hits),
    .trigPulse(trigPulse), .errSticky(errSticky), .errCode(codeQ)
  );

  fam_control uCtrl (
    .hits(hits), .clearErr(clearErr), .strobe(strobe)
  );

  assign errCode = codeQ;

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> !trigPulse && !errSticky && errCode == 2'd0);

endmodule

// File: tb/fillAnomalyMon_test.sv
module fillAnomalyMon_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic [4:0] fillLevel;
  logic       fillValid, rdEvent, wrEvent, clearErr;
  logic       trigPulse, errSticky;
  logic [1:0] errCode;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fillAnomalyMon uut (
    .clk(clk), .rstN(rstN), .fillLevel(fillLevel), .fillValid(fillValid),
    .rdEvent(rdEvent), .wrEvent(wrEvent), .clearErr(clearErr),
    .trigPulse(trigPulse), .errSticky(errSticky), .errCode(errCode)
  );

  // vector: valid rd wr clr fill[5] | expTrig expSticky expCode[2]
  function automatic logic [12:0] mk(input logic v, input logic r, input logic w,
                                     input logic c, input logic [4:0] f,
                                     input logic et, input logic es, input logic [1:0] ec);
    return {v, r, w, c, f, et, es, ec};
  endfunction

  localparam int NV = 19;
  localparam logic [12:0] VEC [NV] = '{
    mk(1,0,0,0,10, 0,0,0), // R2 first sample far from zero
    mk(1,0,1,0,11, 0,0,0), // write raises fill
    mk(1,1,0,0,10, 0,0,0), // read lowers fill
    mk(1,1,1,0,10, 0,0,0), // R6 both events
    mk(1,0,0,0,14, 0,0,0), // R3 step exactly 4
    mk(1,0,0,0, 9, 1,1,1), // R3 step of 5 down
    mk(1,0,0,0, 9, 0,1,1), // R7 pulse lasts one cycle
    mk(1,1,0,0,10, 1,1,1), // R8 later rise keeps code 1
    mk(0,0,0,1, 0, 0,0,0), // R9 clear
    mk(0,1,0,0,31, 0,0,0), // R11 invalid sample ignored
    mk(1,1,0,0,11, 1,1,2), // R4 rise on read vs 10
    mk(1,0,1,0,10, 1,1,2), // R5/R7 consecutive, code held
    mk(1,0,1,1, 9, 1,1,3), // R9 clear with new fall on write
    mk(0,0,0,1, 0, 0,0,0), // R9 clear
    mk(1,1,0,0,20, 1,1,1), // R10 jump plus rise on read
    mk(1,0,0,1,20, 0,0,0), // R9 clear, no change
    mk(1,1,1,0,24, 0,0,0), // R6 step 4 with both events
    mk(1,0,1,0,29, 1,1,1), // R3 step 5 up
    mk(0,0,0,1, 0, 0,0,0)  // R9 final clear
  };

  task automatic check(input string req, input logic et, input logic es, input logic [1:0] ec);
    nRun++;
    if (trigPulse !== et || errSticky !== es || errCode !== ec) begin
      nFail++;
      $display("FAIL %s: got trig=%0b sticky=%0b code=%0d, expected trig=%0b sticky=%0b code=%0d",
               req, trigPulse, errSticky, errCode, et, es, ec);
    end
  endtask

  task automatic drive(input logic v, input logic r, input logic w, input logic c,
                       input logic [4:0] f);
    fillValid = v; rdEvent = r; wrEvent = w; clearErr = c; fillLevel = f;
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; fillValid = 0; rdEvent = 0; wrEvent = 0; clearErr = 0; fillLevel = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", 0, 0, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [12:0] e;
      e = VEC[i];
      drive(e[12], e[11], e[10], e[9], e[8:4]);
      check($sformatf("vector %0d (R2-R11)", i), e[3], e[2], e[1:0]);
    end

    // R7: pulse drops on the cycle after a violation when input is quiet
    drive(1, 0, 0, 0, 29);
    drive(1, 0, 0, 0, 5);
    check("R3 jump 24", 1, 1, 1);
    drive(0, 0, 0, 0, 5);
    check("R7 single-cycle pulse", 0, 1, 1);

    // R1 mid-run reset, then R2 first sample after reset is quiet
    rstN = 1'b0;
    drive(0, 0, 0, 0, 0);
    check("R1 reset clears flags", 0, 0, 0);
    rstN = 1'b1;
    drive(1, 1, 0, 0, 31);
    check("R2 first sample after reset", 0, 0, 0);
    drive(1, 0, 1, 0, 30);
    check("R5 fall on write after rearm", 1, 1, 3);
    drive(1, 1, 1, 0, 30);
    check("R6 no event change", 0, 1, 3);

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got hang, expected completion");
      finishRun();
    end
  end

endmodule